// File: doc/BRIEF.md
# Single-Precision Float Comparator

This block compares two IEEE-754 single-precision operands and returns a one-bit verdict inside a full-width result word, together with an invalid-operation flag for a downstream exception unit. A 3-bit operation code picks one of seven relations: unordered, less-than, equal, less-or-equal, greater-than, not-equal and greater-or-equal. The block sorts operands into quiet NaN, signalling NaN, zero and ordinary values, treats both zeros as equal, and orders everything else by sign and then by magnitude.

Two points need care from the user. Several relations take their operands in the opposite order to their names. The negated relations report true when either input is a NaN. No flag other than invalid is ever produced.

Operands enter on a valid/ready stream, and results leave on a second valid/ready stream one cycle after acceptance. A new operand pair is taken whenever the output slot is empty or is being drained in the same cycle (`cmp_ready = !res_valid || res_ready`). A result that is not taken stays unchanged on the output until `res_ready` is high.

Top module: `fcmp_unit`

## Requirements
- R1: A NaN has an all-ones exponent and a nonzero fraction, and it is signalling when the top fraction bit is 0. Op code 0 (unordered) returns 1 when either operand is a NaN. It raises invalid only if an operand is a signalling NaN.
- R2: Op code 1 (less-than) returns 1 exactly when operand b is ordered below operand a.
- R3: Op code 4 (greater-than) returns 1 exactly when operand a is ordered below operand b.
- R4: Op code 3 (less-or-equal) returns 1 when a is below b or equal to b, and returns 0 when either operand is a NaN.
- R5: Op code 2 (equal) returns 1 for ordered equal operands. Op code 5 (not-equal) is its exact negation, so it returns 1 for unordered inputs.
- R6: Op code 6 (greater-or-equal) is the negation of "a below b", so it returns 1 for unordered inputs.
- R7: Op codes 1, 3, 4 and 6 raise invalid for any NaN operand. Op codes 2 and 5 raise invalid only for a signalling NaN. With no NaN present, no op raises invalid.
- R8: +0 and -0 compare equal and neither is below the other. Operands of different sign are ordered by sign. Two negative operands are ordered by inverted magnitude, and infinities follow the same rule.
- R9: The verdict is in bit 0 of `res_word`, and all other bits are 0.
- R10: A pair accepted on a clock edge appears with `res_valid` high after that edge. While `res_valid` is high and `res_ready` is low, the result and flag hold steady and `cmp_ready` is low.
- R11: Op code 7 is reserved. It returns an all-zero word and never raises invalid, even for signalling NaN operands.
- R12: After reset `res_valid` is 0 and `cmp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Operand pair and op code are valid |
| cmp_ready | output | 1 | Block can take an operand pair |
| cmp_op | input | 3 | Relation select (0 unordered … 6 greater-or-equal, 7 reserved) |
| cmp_a | input | 32 | Operand a |
| cmp_b | input | 32 | Operand b |
| res_valid | output | 1 | Result word and flag are valid |
| res_ready | input | 1 | Consumer takes the result |
| res_word | output | 32 | Verdict in bit 0, zeros elsewhere |
| res_invalid | output | 1 | Invalid-operation flag for this result |

## Verification
The bench aims at the swapped operand order of less-than and greater-than. A design that reads these by their names would give the opposite verdict on 2.0 against 1.0. It sends quiet NaNs to equal and not-equal, where a design that raises invalid for every NaN, or that forgets the negated relations are true when unordered, shows a wrong flag or a wrong verdict. Signed zeros and pairs of negative values test the sign and magnitude ordering: a plain bit-pattern compare would report -0 below +0 and -2.0 above -1.0. A stalled consumer checks that the result holds steady and that new input is refused until the result is drained.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  typedef enum logic [2:0] {
    OP_UNORD = 3'd0,
    OP_LT    = 3'd1,
    OP_EQ    = 3'd2,
    OP_LE    = 3'd3,
    OP_GT    = 3'd4,
    OP_NE    = 3'd5,
    OP_GE    = 3'd6,
    OP_RSVD  = 3'd7
  } fcmp_op_e;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] val,
  output logic         sign,
  output logic         is_nan,
  output logic         is_snan,
  output logic         is_zero,
  output logic [W-2:0] mag
);
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;

  always_comb begin
    sign    = val[W-1];
    expo    = val[W-2 -: EXP_W];
    frac    = val[FRAC_W-1:0];
    mag     = val[W-2:0];
    is_nan  = (&expo) && (|frac);
    // top fraction bit clear marks a signalling NaN
    is_snan = is_nan && !frac[FRAC_W-1];
    is_zero = (mag == '0);
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
  parameter int MAG_W = 31
) (
  input  logic             x_sign,
  input  logic [MAG_W-1:0] x_mag,
  input  logic             x_zero,
  input  logic             y_sign,
  input  logic [MAG_W-1:0] y_mag,
  input  logic             y_zero,
  input  logic             unord,
  output logic             x_below_y
);
  logic both_zero;
  logic raw;

  always_comb begin
    both_zero = x_zero && y_zero;
    if (x_sign != y_sign)
      raw = x_sign;
    else if (x_sign)
      raw = (x_mag > y_mag);
    else
      raw = (x_mag < y_mag);
    x_below_y = !unord && !both_zero && raw;
  end
endmodule

// File: rtl/fcmp_decide.sv
module fcmp_decide
  import fcmp_pkg::*;
(
  input  logic [2:0] op,
  input  logic       unord,
  input  logic       sig_nan,
  input  logic       a_below_b,
  input  logic       b_below_a,
  input  logic       equal,
  output logic       verdict,
  output logic       invalid
);
  fcmp_op_e op_e;

  always_comb begin
    op_e    = fcmp_op_e'(op);
    verdict = 1'b0;
    invalid = 1'b0;
    unique case (op_e)
      OP_UNORD: begin verdict = unord;                  invalid = sig_nan; end
      OP_LT:    begin verdict = b_below_a;              invalid = unord;   end
      OP_EQ:    begin verdict = equal;                  invalid = sig_nan; end
      OP_LE:    begin verdict = a_below_b || equal;     invalid = unord;   end
      OP_GT:    begin verdict = a_below_b;              invalid = unord;   end
      OP_NE:    begin verdict = !equal;                 invalid = sig_nan; end
      OP_GE:    begin verdict = !a_below_b;             invalid = unord;   end
      default:  begin verdict = 1'b0;                   invalid = 1'b0;    end
    endcase
  end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_valid,
  output logic         cmp_ready,
  input  logic [2:0]   cmp_op,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [W-1:0] res_word,
  output logic         res_invalid
);
  localparam int MAG_W = W - 1;

  logic [W-1:0]     opnd [2];
  logic [1:0]       sgn, nan, snan, zro;
  logic [MAG_W-1:0] mag  [2];

  assign opnd[0] = cmp_a;
  assign opnd[1] = cmp_b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) cls_i (
      .val     (opnd[i]),
      .sign    (sgn[i]),
      .is_nan  (nan[i]),
      .is_snan (snan[i]),
      .is_zero (zro[i]),
      .mag     (mag[i])
    );
  end

  logic unord, sig_nan, equal, a_below_b, b_below_a;

  always_comb begin
    unord   = |nan;
    sig_nan = |snan;
    equal   = !unord && ((zro[0] && zro[1]) ||
                         (sgn[0] == sgn[1] && mag[0] == mag[1]));
  end

  fcmp_order #(.MAG_W(MAG_W)) ord_ab_i (
    .x_sign(sgn[0]), .x_mag(mag[0]), .x_zero(zro[0]),
    .y_sign(sgn[1]), .y_mag(mag[1]), .y_zero(zro[1]),
    .unord(unord),   .x_below_y(a_below_b)
  );

  fcmp_order #(.MAG_W(MAG_W)) ord_ba_i (
    .x_sign(sgn[1]), .x_mag(mag[1]), .x_zero(zro[1]),
    .y_sign(sgn[0]), .y_mag(mag[0]), .y_zero(zro[0]),
    .unord(unord),   .x_below_y(b_below_a)
  );

  logic verdict, invalid;

  fcmp_decide dec_i (
    .op(cmp_op), .unord(unord), .sig_nan(sig_nan),
    .a_below_b(a_below_b), .b_below_a(b_below_a), .equal(equal),
    .verdict(verdict), .invalid(invalid)
  );

  logic take;
  assign cmp_ready = !res_valid || res_ready;
  assign take      = cmp_valid && cmp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_word    <= '0;
      res_invalid <= 1'b0;
    end else if (cmp_ready) begin
      res_valid <= cmp_valid;
      if (take) begin
        res_word    <= {{(W-1){1'b0}}, verdict};
        res_invalid <= invalid;
      end
    end
  end
endmodule

// File: rtl/fcmp_unit_chk.sv
module fcmp_unit_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmp_valid,
  input logic         cmp_ready,
  input logic [2:0]   cmp_op,
  input logic [W-1:0] cmp_a,
  input logic [W-1:0] cmp_b,
  input logic         res_valid,
  input logic         res_ready,
  input logic [W-1:0] res_word,
  input logic         res_invalid
);
  logic a_nan;
  assign a_nan = (&cmp_a[W-2 -: EXP_W]) && (|cmp_a[FRAC_W-1:0]);

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_ready |=> res_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_word) && $stable(res_invalid));

  p_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !cmp_ready);

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_word[W-1:1] == '0);

  p_unord_nan_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_ready && cmp_op == 3'd0 && a_nan |=> res_word[0]);

  p_ne_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_ready && cmp_op == 3'd5 && a_nan |=> res_word[0]);

  p_ordered_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_ready && (cmp_op == 3'd1 || cmp_op == 3'd4) && a_nan
    |=> res_invalid);

  p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_ready && cmp_op == 3'd7 |=> res_word == '0 && !res_invalid);

  p_ready_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> cmp_ready);
endmodule

bind fcmp_unit fcmp_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (.*);

// File: tb/fcmp_unit_tb_top.sv
module fcmp_unit_tb_top;
  localparam logic [31:0] P1 = 32'h3F80_0000, P2 = 32'h4000_0000;
  localparam logic [31:0] M1 = 32'hBF80_0000, M2 = 32'hC000_0000;
  localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
  localparam logic [31:0] QN = 32'h7FC0_0000, SN = 32'h7FA0_0000;
  localparam logic [31:0] PI = 32'h7F80_0000, NI = 32'hFF80_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 1'b0;
  logic        cmp_ready;
  logic [2:0]  cmp_op = '0;
  logic [31:0] cmp_a = '0, cmp_b = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [31:0] res_word;
  logic        res_invalid;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  fcmp_unit dut_i (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_cmp(input string tag, input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic exp_r, input logic exp_inv);
    @(negedge clk);
    cmp_op = op; cmp_a = a; cmp_b = b; cmp_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmp_valid = 1'b0;
    check({tag, " valid/word/invalid"}, {res_valid, res_word[30:0], res_invalid},
          {1'b1, 30'd0, exp_r, exp_inv});
  endtask

  task automatic t_reset();
    check("R12 reset state", {30'd0, res_valid, cmp_ready}, {30'd0, 1'b0, 1'b1});
  endtask

  task automatic t_unordered();
    do_cmp("R1 unord ordinary", 3'd0, P1, P2, 1'b0, 1'b0);
    do_cmp("R1 unord quiet",    3'd0, QN, P1, 1'b1, 1'b0);
    do_cmp("R1 unord signal",   3'd0, P1, SN, 1'b1, 1'b1);
    do_cmp("R1 unord infinity", 3'd0, PI, P1, 1'b0, 1'b0);
  endtask

  task automatic t_relational();
    do_cmp("R2 lt b<a",  3'd1, P2, P1, 1'b1, 1'b0);
    do_cmp("R2 lt a<b",  3'd1, P1, P2, 1'b0, 1'b0);
    do_cmp("R3 gt a<b",  3'd4, P1, P2, 1'b1, 1'b0);
    do_cmp("R3 gt b<a",  3'd4, P2, P1, 1'b0, 1'b0);
    do_cmp("R4 le eq",   3'd3, P1, P1, 1'b1, 1'b0);
    do_cmp("R4 le more", 3'd3, P2, P1, 1'b0, 1'b0);
    do_cmp("R4 le less", 3'd3, P1, P2, 1'b1, 1'b0);
    do_cmp("R6 ge more", 3'd6, P2, P1, 1'b1, 1'b0);
    do_cmp("R6 ge less", 3'd6, P1, P2, 1'b0, 1'b0);
  endtask

  task automatic t_equality();
    do_cmp("R5 eq same",    3'd2, P1, P1, 1'b1, 1'b0);
    do_cmp("R5 eq diff",    3'd2, P1, P2, 1'b0, 1'b0);
    do_cmp("R5 ne diff",    3'd5, P1, P2, 1'b1, 1'b0);
    do_cmp("R5 ne quiet",   3'd5, QN, QN, 1'b1, 1'b0);
    do_cmp("R7 eq quiet",   3'd2, QN, P1, 1'b0, 1'b0);
    do_cmp("R7 eq signal",  3'd2, SN, P1, 1'b0, 1'b1);
  endtask

  task automatic t_nan_relational();
    do_cmp("R6 ge quiet", 3'd6, QN, P1, 1'b1, 1'b1);
    do_cmp("R7 lt quiet", 3'd1, QN, P1, 1'b0, 1'b1);
    do_cmp("R7 gt quiet", 3'd4, P1, QN, 1'b0, 1'b1);
    do_cmp("R7 le quiet", 3'd3, QN, QN, 1'b0, 1'b1);
  endtask

  task automatic t_signs();
    do_cmp("R8 eq zeros",      3'd2, PZ, NZ, 1'b1, 1'b0);
    do_cmp("R8 lt zeros",      3'd1, PZ, NZ, 1'b0, 1'b0);
    do_cmp("R8 gt -2<-1",      3'd4, M2, M1, 1'b1, 1'b0);
    do_cmp("R8 gt -1<-2",      3'd4, M1, M2, 1'b0, 1'b0);
    do_cmp("R8 gt -inf<-1",    3'd4, NI, M1, 1'b1, 1'b0);
    do_cmp("R8 gt -1<+1",      3'd4, M1, P1, 1'b1, 1'b0);
  endtask

  task automatic t_reserved();
    do_cmp("R11 reserved op", 3'd7, SN, SN, 1'b0, 1'b0);
    check("R9 upper bits", res_word, 32'd0);
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    @(negedge clk);
    res_ready = 1'b0;
    cmp_op = 3'd4; cmp_a = M1; cmp_b = P1; cmp_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10 first result", {res_valid, res_word[0]}, 32'd3);
    held = {res_word[30:0], res_invalid};
    cmp_op = 3'd1; cmp_a = M1; cmp_b = P1;
    check("R10 ready low under stall", {31'd0, cmp_ready}, 32'd0);
    repeat (3) @(negedge clk);
    check("R10 held during stall", {res_valid, res_word[30:0], res_invalid}, {1'b1, held});
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmp_valid = 1'b0;
    check("R10 second result after drain", {res_valid, res_word[30:0], res_invalid},
          {1'b1, 31'd0, 1'b0});
    @(negedge clk);
    check("R10 drained", {31'd0, res_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unordered();
    t_relational();
    t_equality();
    t_nan_relational();
    t_signs();
    t_reserved();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule